// File: doc/BRIEF.md
# ADC-to-Down-Converter Routing Crossbar

This block steers four sampled converter streams onto the eight sample inputs of four down-converters. Each down-converter takes an in-phase input and a quadrature input. A 32-bit routing word holds one 4-bit selector per input. A selector names the converter whose samples feed that input. On a quadrature input, a reserved selector code ties the input to constant zero instead. This lets a real-only signal enter a complex mixer. It also lets one converter be split across several down-converters.

Software writes the routing word through a simple write strobe. A word that breaks the encoding rules is refused: the active routing stays as it was, and a sticky error flag is raised. An accepted word waits in a pending slot. It is applied to the first sample strobe that arrives in a cycle after the write, so no output sample ever mixes two configurations. Routed samples are registered, and a valid flag travels with them.

Top module: `adc_route_xbar`

## Requirements
- R1: For down-converter k (k = 0..3), the selector for its in-phase input sits at bits [8k+3:8k] of the routing word. After a strobe, the in-phase output for k carries the sample of the converter whose index equals that selector.
- R2: For down-converter k, the selector for its quadrature input sits at bits [8k+7:8k+4]. The values 0..3 pick a converter, and the value 0xF drives a quadrature output of zero.
- R3: One converter may feed any number of inputs at the same time. For example, the word 0x22222222 puts converter 2 on all eight outputs.
- R4: A routing word is illegal if any in-phase selector is above 3, or if any quadrature selector lies in 4..14.
- R5: A routing word is illegal unless either all four quadrature selectors are 0xF or none of them is.
- R6: A write of an illegal word leaves the routing unchanged. The next strobe routes exactly as it would have without that write.
- R7: `cfg_err` rises in the cycle after an illegal write and stays high until `err_clr` is asserted. If `err_clr` and an illegal write arrive in the same cycle, the flag stays set.
- R8: A strobe sampled at one clock edge updates the outputs at that edge. `out_vld` is high for exactly the cycle that follows each strobe cycle. Without a strobe, the outputs hold their values.
- R9: A legal word applies to the first strobe in a later cycle than its write. A strobe in the same cycle as the write still uses the previous routing. If several legal words arrive before a strobe, the last one wins.
- R10: After reset, the outputs are zero, `out_vld` and `cfg_err` are low, and the routing word is 0xF0F0F1F0. That word routes converter 0 to in-phase inputs 0, 2 and 3, converter 1 to in-phase input 1, and zero to every quadrature input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Routing word write strobe |
| cfg_wdata | input | 32 | Routing word to write |
| err_clr | input | 1 | Clears the sticky error flag |
| cfg_err | output | 1 | Sticky flag: an illegal word was refused |
| adc_stb | input | 1 | Converter sample strobe |
| adc_smp | input | 48 | Four 12-bit signed samples; converter n occupies bits [12n+11:12n] |
| out_vld | output | 1 | Routed samples were updated by the last edge |
| ddc_i_out | output | 48 | In-phase inputs; down-converter k at [12k+11:12k] |
| ddc_q_out | output | 48 | Quadrature inputs; down-converter k at [12k+11:12k] |

## Verification
The bench targets the cases a crossbar is most likely to get wrong:
- A write that coincides with a strobe. A design that applied the word at once would switch routing one sample early.
- Illegal words of two kinds: an out-of-range selector, and a mix of zero and non-zero quadrature selectors. A design that checked only the range would accept the mix and emit a half-real, half-complex configuration.
- An error clear that coincides with a new illegal write. A design that let the clear win would lose the error.
- Broadcast routing and the reset default. Faulty index arithmetic would show up as samples taken from the wrong converter slice.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int SEL_W = 4;
  localparam int N_ADC = 4;
  localparam int N_DDC = 4;
  localparam int CFG_W = 2 * SEL_W * N_DDC;
  localparam logic [SEL_W-1:0] ZERO_SEL = '1;
  localparam logic [CFG_W-1:0] DEF_CFG = 32'hF0F0_F1F0;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CFG_W-1:0] cfg_t;

  // selector of the in-phase input of down-converter k
  function automatic sel_t fld_i(cfg_t c, int k);
    return c[2*SEL_W*k +: SEL_W];
  endfunction

  // selector of the quadrature input of down-converter k
  function automatic sel_t fld_q(cfg_t c, int k);
    return c[2*SEL_W*k+SEL_W +: SEL_W];
  endfunction

  // range rules plus the all-or-none zero-quadrature rule
  function automatic logic cfg_legal(cfg_t c);
    int   nzero;
    logic ok;
    nzero = 0;
    ok    = 1'b1;
    for (int k = 0; k < N_DDC; k++) begin
      if (fld_i(c, k) >= sel_t'(N_ADC)) ok = 1'b0;
      if (fld_q(c, k) == ZERO_SEL) nzero++;
      else if (fld_q(c, k) >= sel_t'(N_ADC)) ok = 1'b0;
    end
    return ok && (nzero == 0 || nzero == N_DDC);
  endfunction

  // a legal word is in real-input mode when its first quadrature field is zero
  function automatic logic cfg_zero_q(cfg_t c);
    return fld_q(c, 0) == ZERO_SEL;
  endfunction
endpackage

// File: rtl/xbar_cfg_reg.sv
module xbar_cfg_reg
  import xbar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  cfg_t wr_data,
  input  logic err_clr,
  input  logic smp_stb,
  output cfg_t eff_cfg,
  output logic wr_bad,
  output logic err_flag
);
  cfg_t act_q, pend_q;
  logic pend_vld;
  logic wr_ok;
  logic wr_good;

  assign wr_ok   = cfg_legal(wr_data);
  assign wr_good = wr_en && wr_ok;
  assign wr_bad  = wr_en && !wr_ok;
  // routing seen by a strobe in this cycle
  assign eff_cfg = pend_vld ? pend_q : act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= DEF_CFG;
      pend_q   <= DEF_CFG;
      pend_vld <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (smp_stb) act_q <= eff_cfg;
      if (wr_good) begin
        pend_q   <= wr_data;
        pend_vld <= 1'b1;
      end else if (smp_stb) begin
        pend_vld <= 1'b0;
      end
      if (wr_bad)       err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/xbar_lane.sv
module xbar_lane
  import xbar_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter bit IS_Q  = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stb,
  input  sel_t                   sel,
  input  logic [N_ADC*SMP_W-1:0] adc,
  output logic [SMP_W-1:0]       smp_out
);
  logic [SMP_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int a = 0; a < N_ADC; a++)
      if (sel == sel_t'(a)) nxt = adc[a*SMP_W +: SMP_W];
    if (IS_Q && sel == ZERO_SEL) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   smp_out <= '0;
    else if (stb) smp_out <= nxt;
  end
endmodule

// File: rtl/adc_route_xbar.sv
module adc_route_xbar
  import xbar_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CFG_W-1:0]       cfg_wdata,
  input  logic                   err_clr,
  output logic                   cfg_err,
  input  logic                   adc_stb,
  input  logic [N_ADC*SMP_W-1:0] adc_smp,
  output logic                   out_vld,
  output logic [N_DDC*SMP_W-1:0] ddc_i_out,
  output logic [N_DDC*SMP_W-1:0] ddc_q_out
);
  cfg_t eff_cfg;
  logic wr_bad;
  logic zero_q_now;

  xbar_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_data  (cfg_wdata),
    .err_clr  (err_clr),
    .smp_stb  (adc_stb),
    .eff_cfg  (eff_cfg),
    .wr_bad   (wr_bad),
    .err_flag (cfg_err)
  );

  assign zero_q_now = cfg_zero_q(eff_cfg);

  for (genvar k = 0; k < N_DDC; k++) begin : g_ddc
    xbar_lane #(.SMP_W(SMP_W), .IS_Q(1'b0)) u_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (adc_stb),
      .sel     (fld_i(eff_cfg, k)),
      .adc     (adc_smp),
      .smp_out (ddc_i_out[k*SMP_W +: SMP_W])
    );
    xbar_lane #(.SMP_W(SMP_W), .IS_Q(1'b1)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (adc_stb),
      .sel     (fld_q(eff_cfg, k)),
      .adc     (adc_smp),
      .smp_out (ddc_q_out[k*SMP_W +: SMP_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= adc_stb;
  end
endmodule

// File: rtl/adc_route_xbar_chk.sv
module adc_route_xbar_chk
  import xbar_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   adc_stb,
  input logic                   out_vld,
  input logic [N_DDC*SMP_W-1:0] ddc_i_out,
  input logic [N_DDC*SMP_W-1:0] ddc_q_out,
  input logic                   err_clr,
  input logic                   cfg_err,
  input logic                   wr_bad,
  input logic                   zero_q_now,
  input cfg_t                   eff_cfg
);
  a_r8_vld_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    adc_stb |=> out_vld);
  a_r8_vld_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_stb |=> !out_vld);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_stb |=> ($stable(ddc_i_out) && $stable(ddc_q_out)));
  a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> cfg_err);
  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !wr_bad) |=> !cfg_err);
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !err_clr) |=> cfg_err);
  a_r2_zero_q: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_stb && zero_q_now) |=> (ddc_q_out == '0));

  // R5 / R6: the routing in force is always a legal word
  always_ff @(posedge clk)
    if (rst_n) a_r5_eff_legal: assert (cfg_legal(eff_cfg));
endmodule

bind adc_route_xbar adc_route_xbar_chk #(.SMP_W(SMP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adc_stb    (adc_stb),
  .out_vld    (out_vld),
  .ddc_i_out  (ddc_i_out),
  .ddc_q_out  (ddc_q_out),
  .err_clr    (err_clr),
  .cfg_err    (cfg_err),
  .wr_bad     (wr_bad),
  .zero_q_now (zero_q_now),
  .eff_cfg    (eff_cfg)
);

// File: tb/adc_route_xbar_bench.sv
module adc_route_xbar_bench;
  localparam int W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        err_clr = 1'b0;
  logic        cfg_err;
  logic        adc_stb = 1'b0;
  logic [47:0] adc_smp = '0;
  logic        out_vld;
  logic [47:0] ddc_i_out, ddc_q_out;

  int unsigned n_run = 0, n_fail = 0;

  // bench model state
  logic [31:0] m_act, m_pend;
  logic        m_pflag, m_err, m_vld;
  logic [47:0] m_i, m_q;

  always #5 clk = ~clk;

  adc_route_xbar #(.SMP_W(W)) u_adc_route_xbar (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .err_clr(err_clr), .cfg_err(cfg_err), .adc_stb(adc_stb), .adc_smp(adc_smp),
    .out_vld(out_vld), .ddc_i_out(ddc_i_out), .ddc_q_out(ddc_q_out)
  );

  function automatic logic [3:0] nib(logic [31:0] w, int n);
    return 4'((w >> (4 * n)) & 32'hF);
  endfunction

  // legality restated from R4 and R5
  function automatic logic b_legal(logic [31:0] w);
    int zeros = 0;
    for (int k = 0; k < 4; k++) begin
      if (nib(w, 2*k) > 4'd3) return 1'b0;
      if (nib(w, 2*k+1) == 4'hF) zeros++;
      else if (nib(w, 2*k+1) > 4'd3) return 1'b0;
    end
    return (zeros == 0) || (zeros == 4);
  endfunction

  function automatic logic [11:0] b_pick(logic [31:0] w, logic [47:0] a, int k, bit q);
    logic [3:0] s = nib(w, 2*k + (q ? 1 : 0));
    if (q && s == 4'hF) return 12'd0;
    return 12'(a >> (12 * s));
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock cycle: drive at negedge, model at posedge, compare after the edge
  task automatic step(logic we, logic [31:0] wd, logic clr, logic stb, string tag);
    logic [31:0] eff;
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd; err_clr = clr; adc_stb = stb;
    adc_smp = {$urandom, $urandom};
    @(posedge clk);
    eff = m_pflag ? m_pend : m_act;
    if (stb) begin
      for (int k = 0; k < 4; k++) begin
        m_i[12*k +: 12] = b_pick(eff, adc_smp, k, 1'b0);
        m_q[12*k +: 12] = b_pick(eff, adc_smp, k, 1'b1);
      end
      m_act = eff;
      m_pflag = 1'b0;
    end
    m_vld = stb;
    if (we && b_legal(wd)) begin m_pend = wd; m_pflag = 1'b1; end
    if (we && !b_legal(wd)) m_err = 1'b1;
    else if (clr) m_err = 1'b0;
    #1;
    check(tag, "i_out", 64'(ddc_i_out), 64'(m_i));
    check(tag, "q_out", 64'(ddc_q_out), 64'(m_q));
    check("R8", "out_vld", 64'(out_vld), 64'(m_vld));
    check("R7", "cfg_err", 64'(cfg_err), 64'(m_err));
  endtask

  function automatic logic [31:0] rnd_legal();
    logic [31:0] w = '0;
    bit zq = $urandom % 2;
    for (int k = 0; k < 4; k++) begin
      w[8*k +: 4]   = 4'($urandom % 4);
      w[8*k+4 +: 4] = zq ? 4'hF : 4'($urandom % 4);
    end
    return w;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    m_act = 32'hF0F0_F1F0; m_pend = m_act; m_pflag = 0; m_err = 0; m_vld = 0;
    m_i = '0; m_q = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10", "i_out", 64'(ddc_i_out), 64'd0);
    check("R10", "q_out", 64'(ddc_q_out), 64'd0);
    check("R10", "out_vld", 64'(out_vld), 64'd0);
    check("R10", "cfg_err", 64'(cfg_err), 64'd0);
    step(0, 0, 0, 1, "R10");                 // default routing
    step(0, 0, 0, 0, "R8");                  // hold without strobe
    step(1, 32'h2301_3210, 0, 0, "R8");      // quadrature routing written
    step(0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, "R1");
    step(0, 0, 0, 1, "R2");
    step(1, 32'h2222_2222, 0, 0, "R3");      // broadcast
    step(0, 0, 0, 1, "R3");
    step(1, 32'hF0F0_F1F4, 0, 0, "R4");      // in-phase selector out of range
    step(0, 0, 0, 1, "R6");
    step(0, 0, 1, 0, "R7");
    step(1, 32'hF0F0_F1E0, 0, 0, "R4");      // quadrature selector 0xE
    step(0, 0, 1, 1, "R6");
    step(1, 32'hF0F0_F110, 0, 0, "R5");      // mixed zero and non-zero Q
    step(0, 0, 0, 1, "R6");
    step(1, 32'hFFFF_FFFF, 1, 0, "R7");      // clear and illegal write together
    step(0, 0, 1, 0, "R7");
    step(1, 32'h0123_0123, 0, 1, "R9");      // write with strobe: old routing
    step(0, 0, 0, 1, "R9");                  // now the new routing
    step(1, 32'hF3F2_F1F0, 0, 0, "R9");
    step(1, 32'h1111_1111, 0, 0, "R9");      // last legal write wins
    step(1, 32'h4444_4444, 0, 0, "R6");
    step(0, 0, 0, 1, "R9");
    step(0, 0, 1, 0, "R7");
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 8;
      logic [31:0] w = (r < 3) ? rnd_legal() : $urandom;
      step(r < 5, w, ($urandom % 6) == 0, ($urandom % 3) != 0, "R1");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule